// File: doc/BRIEF.md
# Jitter-Absorbing Elastic Bit Buffer

This block is a dual-clock elastic store for a two-rail line signal. One positive-rail bit and one negative-rail bit are kept per unit interval. Writes follow the jittered recovered line clock, and the pair is captured on its falling edge. Reads follow a steady local reference clock, and the output pair is updated on its rising edge. Because the read pointer trails the write pointer by about half the buffer, short-term phase wander on the line side is absorbed. The output then carries only the long-term rate of the line.

The usable depth is either 128 or 32 entries. A shallower store gives less throughput delay, but it tolerates less wander. A falling edge on the recenter input places the read pointer half a buffer behind the write pointer again. Data in flight may be corrupted when this happens. A limit flag reports that the occupancy has come close to either end of the store. A pass-through mode ignores the store and routes the line clock and both rails straight to the outputs.

Top module: `jitter_elastic_store`

## Requirements
- R1: Each read-clock rising edge presents the next stored pair in write order. The positive rail appears on out_pos and the negative rail on out_neg. Each pair is captured from line_pos/line_neg on a falling edge of line_clk.
- R2: After power-up reset, the read side trails the write side by half the selected depth. Measured as entries written after the pair currently shown, the lag is between D/2-3 and D/2+8.
- R3: short_sel low selects 128 entries and high selects 32 entries. The value is taken only at power-up or at a recenter, so a change on its own leaves the lag unchanged.
- R4: A high-to-low transition of recenter puts the read pointer half the selected depth behind the write pointer. The write pointer keeps its position modulo the depth. Holding recenter high or low has no effect.
- R5: at_limit is registered on ref_clk and is low in reset. For occupancy F it is high when F <= 4 or F >= 124 at depth 128, and when F <= 2 or F >= 30 at depth 32. It is low otherwise.
- R6: With pass_thru high, out_clk equals line_clk, out_pos equals line_pos and out_neg equals line_neg, with no register in the path. at_limit is held low.
- R7: The write pointer crosses to the read domain as Gray code through two flops. It changes by at most one bit per write, except on a write that applies a recenter.
- R8: Except at a recenter, the read pointer advances by exactly one per read clock, modulo the selected depth. A steady rate keeps a steady lag.
- R9: Two read clocks after a recenter, at_limit is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| arst_n | input | 1 | Asynchronous power-up reset, active low |
| line_clk | input | 1 | Jittered recovered line clock (write side) |
| line_pos | input | 1 | Positive-rail line bit |
| line_neg | input | 1 | Negative-rail line bit |
| ref_clk | input | 1 | Smooth local read clock |
| short_sel | input | 1 | Depth select: 0 = 128 entries, 1 = 32 entries |
| recenter | input | 1 | Falling edge recenters the pointers |
| pass_thru | input | 1 | 1 = route line clock and data directly to outputs |
| out_clk | output | 1 | Output clock (ref_clk, or line_clk in pass-through) |
| out_pos | output | 1 | Positive-rail output bit |
| out_neg | output | 1 | Negative-rail output bit |
| at_limit | output | 1 | Occupancy near full or near empty |

## Verification
The assertions rely on several input conditions. The two clocks must run at nearly the same rate, so that at most a couple of writes fall between read edges. recenter must stay at each level long enough for both two-flop synchronizers to see it. short_sel must change only while the block is not recentering. The stimulus keeps within these limits. Rate offsets are at most 25 percent and last only long enough to move the occupancy toward one end. Each recenter pulse lasts ten read clocks, and depth changes are made well apart from pulses. The write clock is stopped only to drain the store on purpose, and it is restarted before any recenter.

// File: rtl/jitter_elastic_store.sv
module jitter_elastic_store #(
  parameter int DEEP           = 128,
  parameter int SHALLOW        = 32,
  parameter int DEEP_MARGIN    = 4,
  parameter int SHALLOW_MARGIN = 2
) (
  input  logic arst_n,
  input  logic line_clk,
  input  logic line_pos,
  input  logic line_neg,
  input  logic ref_clk,
  input  logic short_sel,
  input  logic recenter,
  input  logic pass_thru,
  output logic out_clk,
  output logic out_pos,
  output logic out_neg,
  output logic at_limit
);
  localparam int AW = $clog2(DEEP);
  localparam logic [AW-1:0] DEEP_MASK    = AW'(DEEP - 1);
  localparam logic [AW-1:0] SHALLOW_MASK = AW'(SHALLOW - 1);
  localparam logic [AW-1:0] DEEP_HALF    = AW'(DEEP / 2);
  localparam logic [AW-1:0] SHALLOW_HALF = AW'(SHALLOW / 2);
  localparam logic [AW-1:0] DEEP_LO      = AW'(DEEP_MARGIN);
  localparam logic [AW-1:0] SHALLOW_LO   = AW'(SHALLOW_MARGIN);
  localparam logic [AW-1:0] DEEP_HI      = AW'(DEEP - DEEP_MARGIN);
  localparam logic [AW-1:0] SHALLOW_HI   = AW'(SHALLOW - SHALLOW_MARGIN);

  logic [1:0] mem [DEEP];

  // write side, falling edge of the line clock
  logic [1:0]    w_rc;
  logic          w_rc_d, w_first, w_short, w_cen;
  logic [AW-1:0] w_bin, w_next, w_gray, w_mask;

  assign w_cen  = w_first | (w_rc_d & ~w_rc[1]);
  assign w_mask = (w_cen ? short_sel : w_short) ? SHALLOW_MASK : DEEP_MASK;
  assign w_next = (w_bin + 1'b1) & w_mask;

  always_ff @(negedge line_clk or negedge arst_n)
    if (!arst_n) begin
      w_rc    <= '0;
      w_rc_d  <= 1'b0;
      w_first <= 1'b1;
      w_short <= 1'b0;
      w_bin   <= '0;
      w_gray  <= '0;
    end else begin
      w_rc    <= {w_rc[0], recenter};
      w_rc_d  <= w_rc[1];
      w_first <= 1'b0;
      if (w_cen) w_short <= short_sel;
      w_bin   <= w_next;
      w_gray  <= w_next ^ (w_next >> 1);
    end

  always_ff @(negedge line_clk)
    mem[w_bin] <= {line_pos, line_neg};

  // read side, rising edge of the reference clock
  logic [AW-1:0] g_s1, g_s2, r_wbin, r_ptr, r_fill, r_mask, r_lo, r_hi;
  logic [1:0]    r_rc, r_q;
  logic          r_rc_d, r_first, r_short, r_cen, r_lim;

  always_comb begin
    r_wbin[AW-1] = g_s2[AW-1];
    for (int i = AW - 2; i >= 0; i--) r_wbin[i] = r_wbin[i+1] ^ g_s2[i];
  end

  assign r_cen  = r_first | (r_rc_d & ~r_rc[1]);
  assign r_mask = r_short ? SHALLOW_MASK : DEEP_MASK;
  assign r_lo   = r_short ? SHALLOW_LO : DEEP_LO;
  assign r_hi   = r_short ? SHALLOW_HI : DEEP_HI;
  assign r_fill = (r_wbin - r_ptr) & r_mask;

  always_ff @(posedge ref_clk or negedge arst_n)
    if (!arst_n) begin
      g_s1    <= '0;
      g_s2    <= '0;
      r_rc    <= '0;
      r_rc_d  <= 1'b0;
      r_first <= 1'b1;
      r_short <= 1'b0;
      r_ptr   <= '0;
      r_q     <= '0;
      r_lim   <= 1'b0;
    end else begin
      g_s1    <= w_gray;
      g_s2    <= g_s1;
      r_rc    <= {r_rc[0], recenter};
      r_rc_d  <= r_rc[1];
      r_first <= 1'b0;
      if (r_cen) begin
        r_short <= short_sel;
        r_ptr   <= (r_wbin - (short_sel ? SHALLOW_HALF : DEEP_HALF)) &
                   (short_sel ? SHALLOW_MASK : DEEP_MASK);
      end else begin
        r_ptr   <= (r_ptr + 1'b1) & r_mask;
      end
      r_q   <= mem[r_ptr];
      r_lim <= (r_fill <= r_lo) || (r_fill >= r_hi);
    end

  assign out_clk  = pass_thru ? line_clk : ref_clk;
  assign out_pos  = pass_thru ? line_pos : r_q[1];
  assign out_neg  = pass_thru ? line_neg : r_q[0];
  assign at_limit = ~pass_thru & r_lim;

  // R7
  wgray_onebit_chk: assert property (@(negedge line_clk) disable iff (!arst_n)
    !w_cen |=> $countones(w_gray ^ $past(w_gray)) <= 1);

  // R8
  rptr_step_chk: assert property (@(posedge ref_clk) disable iff (!arst_n)
    !r_cen |=> r_ptr == (($past(r_ptr) + 1'b1) & r_mask));

  // R3
  depth_hold_chk: assert property (@(posedge ref_clk) disable iff (!arst_n)
    !r_cen |=> $stable(r_short));

  // R9
  recenter_clear_chk: assert property (@(posedge ref_clk) disable iff (!arst_n)
    r_cen |=> ##1 !r_lim);
endmodule

// File: tb/test_jitter_elastic_store.sv
module test_jitter_elastic_store;
  localparam int TCLK = 10;
  localparam logic [6:0] BYP [8] = '{7'b000_0000, 7'b001_0010, 7'b010_0100, 7'b011_0110,
                                     7'b100_1000, 7'b101_1010, 7'b110_1100, 7'b111_1110};

  logic arst_n, wclk, wp, wn, rclk, short_sel, recenter, pass;
  logic out_clk, out_pos, out_neg, at_limit;
  int whalf = TCLK / 2, rhalf = TCLK / 2;
  bit wrun = 1, done = 0;
  int nchk = 0, nbad = 0, wcnt = 0, ocnt = 0;
  logic [1:0] s [65536];
  logic [1:0] o [65536];
  logic [15:0] lf = 16'hACE1;

  jitter_elastic_store i_jitter_elastic_store (
    .arst_n(arst_n), .line_clk(wclk), .line_pos(wp), .line_neg(wn), .ref_clk(rclk),
    .short_sel(short_sel), .recenter(recenter), .pass_thru(pass),
    .out_clk(out_clk), .out_pos(out_pos), .out_neg(out_neg), .at_limit(at_limit));

  initial begin
    wclk = 0;
    forever begin #(whalf); if (wrun) wclk = ~wclk; end
  end
  initial begin
    rclk = 0; #2;
    forever begin #(rhalf); rclk = ~rclk; end
  end

  always @(posedge wclk) if (!pass) begin
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    wp = lf[0]; wn = lf[5];
    s[16'(wcnt)] = {lf[0], lf[5]};
    wcnt++;
  end
  always @(negedge rclk) if (!pass) begin
    o[16'(ocnt)] = {out_pos, out_neg};
    ocnt++;
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
  endtask
  task automatic chk_eq(string req, int act, int exp);
    nchk++;
    if (act != exp) begin nbad++; $display("FAIL %s: got %0d, expected %0d", req, act, exp); end
  endtask
  task automatic chk_rng(string req, int act, int lo, int hi);
    nchk++;
    if (act < lo || act > hi) begin
      nbad++; $display("FAIL %s: got %0d, expected %0d..%0d", req, act, lo, hi);
    end
  endtask
  task automatic cyc(int n);
    repeat (n) @(negedge rclk);
  endtask
  task automatic pulse();
    recenter = 1; cyc(10); recenter = 0; cyc(10);
  endtask
  task automatic measure(output int lag);
    @(negedge rclk); #1;
    lag = -1;
    for (int l = 0; l <= 200 && lag < 0; l++) begin
      int i;
      bit ok;
      i = wcnt - l; ok = 1;
      if (i >= 17 && ocnt >= 17) begin
        for (int k = 0; k < 16; k++)
          if (s[16'(i - 16 + k)] !== o[16'(ocnt - 16 + k)]) ok = 0;
        if (ok) lag = l;
      end
    end
  endtask
  task automatic until_limit(int maxn, output int n);
    n = 0;
    while (!at_limit && n < maxn) begin @(negedge rclk); n++; end
  endtask

  initial begin
    #(TCLK * 150000);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog: got hung run, expected completion");
      summary(); $finish;
    end
  end

  initial begin
    int lag0, lag1, lag2, lag3, lag4, lag5, lag6, lag7, lag8, n;
    arst_n = 0; short_sel = 0; recenter = 0; pass = 0; wp = 0; wn = 0;
    cyc(4);
    chk_eq("R5 limit low in reset", at_limit, 0);
    arst_n = 1;
    cyc(400);
    measure(lag0);
    chk_rng("R2 power-up centre, depth 128", lag0, 61, 72);
    chk_eq("R5 limit low when centred", at_limit, 0);
    cyc(500);
    measure(lag1);
    chk_eq("R1 R7 stream intact", int'(lag1 >= 0), 1);
    chk_rng("R8 steady lag", lag1, lag0 - 1, lag0 + 1);
    whalf = 4; cyc(100); whalf = TCLK / 2; cyc(50);
    measure(lag2);
    chk_rng("R8 lag grows with write excess", lag2, lag0 + 18, lag0 + 32);
    chk_eq("R5 limit low at mid-high fill", at_limit, 0);
    recenter = 1; cyc(200);
    measure(lag3);
    chk_rng("R4 held high ignored", lag3, lag2 - 1, lag2 + 1);
    recenter = 0; cyc(200);
    measure(lag4);
    chk_rng("R4 falling edge recentres", lag4, 61, 72);
    short_sel = 1; cyc(200);
    measure(lag5);
    chk_rng("R3 select waits for recentre", lag5, lag4 - 1, lag4 + 1);
    pulse(); cyc(200);
    measure(lag6);
    chk_rng("R3 shallow depth lag", lag6, 13, 24);
    wrun = 0;
    until_limit(100, n);
    chk_rng("R5 near-empty at depth 32", n, 12, 26);
    wrun = 1; pulse(); cyc(100);
    chk_eq("R9 limit clear after recentre", at_limit, 0);
    measure(lag7);
    chk_rng("R4 recentre at depth 32", lag7, 13, 24);
    whalf = 4;
    until_limit(200, n);
    chk_rng("R5 near-full at depth 32", n, 36, 80);
    whalf = TCLK / 2; pulse(); cyc(100);
    chk_eq("R9 limit clear after full", at_limit, 0);
    short_sel = 0; pulse(); cyc(300);
    measure(lag8);
    chk_rng("R3 back to depth 128", lag8, 61, 72);
    wrun = 0;
    until_limit(150, n);
    chk_rng("R5 near-empty at depth 128", n, 56, 74);
    #1 pass = 1; #2;
    chk_eq("R6 limit masked in pass-through", at_limit, 0);
    for (int v = 0; v < 8; v++) begin
      {wclk, wp, wn} = BYP[v][6:4];
      #2;
      chk_eq("R6 pass-through vector", int'({out_clk, out_pos, out_neg, at_limit}),
             int'(BYP[v][3:0]));
    end
    done = 1;
    summary();
    $finish;
  end
endmodule